// File: doc/BRIEF.md
# Byte-wide host register port

This block is a slave port through which an external host reads and writes 16-bit registers of a processor core over an 8-bit bidirectional data bus. The host uses separate active-low strobes: a port select, a read strobe and a write strobe. Two more inputs qualify each access. One picks the byte lane. The other picks between the data registers and a status word. Every host input, the data bus included, is brought into the core clock domain through a multi-stage synchronizer before any edge is detected.

A transfer exists only while the port select and one strobe are both low. It therefore opens on whichever of the two falls later and closes on whichever rises first. The lane and status selects are taken at the opening of a transfer. A written byte is taken from the synchronized bus in the cycle the closing is seen. A 16-bit word is moved as two byte transfers, and a single byte transfer behaves exactly like one half of such a pair. For fast release, the bus output enable comes straight from the raw select and read strobe. The core side loads the outgoing word and consumes the incoming word, and a full flag tracks each direction.

Top module: `byte_host_port`

## Requirements
- R1: After reset both full flags are 0, the input word is 0 and the port does not drive the data bus.
- R2: A read transfer opens only once both the port select and the read strobe are low, on the later of the two falling edges. It closes on the earlier of the two rising edges.
- R3: A write transfer opens and closes by the same rule using the write strobe. The stored byte is the bus value sampled together with the closing edge, so bus changes after that edge are not stored.
- R4: A lane select of 0 addresses bits 7:0 of the 16-bit word and 1 addresses bits 15:8. The lane and status selects are taken at the opening of the transfer.
- R5: The data bus is driven only while the raw port select and the raw read strobe are both low. It carries the byte chosen by the current selects.
- R6: A read with the status select at 1 returns the status word instead of the outgoing word. Its low byte holds the input-full flag in bit 0 and the output-full flag in bit 1, and every other bit, the whole high byte included, reads 0.
- R7: The input-full flag sets when a high-lane data write closes and clears on a core take pulse. If both occur in the same cycle, the set wins.
- R8: A core load pulse stores the outgoing word and sets the output-full flag. The flag clears when a high-lane data read closes. If both occur in the same cycle, the load wins.
- R9: A write with the status select at 1 changes neither the input word nor the input-full flag.
- R10: A host edge that arrives between clock edges k-1 and k takes effect on the core-side outputs at clock edge k+2 when two synchronizer stages are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host port select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_bsel | input | 1 | Byte lane: 0 low byte, 1 high byte |
| host_ssel | input | 1 | 1 selects the status word for reads |
| host_data | inout | BYTE_W | Bidirectional host data bus |
| core_out_data | input | 2*BYTE_W | Word to be offered to the host |
| core_out_load | input | 1 | Core pulse that loads core_out_data |
| core_in_data | output | 2*BYTE_W | Word written by the host |
| core_in_full | output | 1 | Input-full flag |
| core_in_take | input | 1 | Core pulse that consumes the input word |
| core_out_full | output | 1 | Output-full flag |

## Verification
The bench builds the port with BYTE_W of 8 and SYNC_STAGES of 2. At that width, lane selection, the status bit layout and every byte value fit in short transfers. The reference model delays the host pins through a queue whose depth is SYNC_STAGES. This puts the exact clock edge at which a host edge takes effect within reach of a per-cycle comparison. Transfers run with the port select both leading and lagging the strobe, and the selects and the bus change partway through a transfer. This shows that the later falling edge opens a transfer and the earlier rising edge closes it.

// File: rtl/hp_pkg.sv
// Package: shared constants of the byte-wide host port.
// Assumes: status flags occupy the low bits of the status word.
package hp_pkg;
    localparam int STAT_IN_FULL_BIT  = 0;
    localparam int STAT_OUT_FULL_BIT = 1;
endpackage

// File: rtl/hp_sync.sv
// Multi-stage synchronizer for a vector of asynchronous host pins.
// Assumes: STAGES >= 1; the reset value is the idle state of the pins.
module hp_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   IDLE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // Shift the raw sample through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hp_framer.sv
// Transfer framer: forms read and write transfer windows from the
// synchronized select and strobes, emits open/close pulses, latches the
// lane and status selects at each opening and makes the bus enable.
// Assumes: inputs s_* are already synchronized; raw_* are the pins.
module hp_framer (
    input  logic clk,
    input  logic rst_n,
    input  logic s_cs_n,
    input  logic s_rd_n,
    input  logic s_wr_n,
    input  logic s_bsel,
    input  logic s_ssel,
    input  logic raw_cs_n,
    input  logic raw_rd_n,
    output logic rd_close,
    output logic wr_close,
    output logic sel_bsel,
    output logic sel_ssel,
    output logic bus_oe
);
    logic rd_win, wr_win, rd_win_q, wr_win_q, rd_open, wr_open;

    // A window is open only while the select and its strobe are both low.
    assign rd_win   = !s_cs_n && !s_rd_n;
    assign wr_win   = !s_cs_n && !s_wr_n;
    assign rd_open  = rd_win && !rd_win_q;
    assign wr_open  = wr_win && !wr_win_q;
    assign rd_close = !rd_win && rd_win_q;
    assign wr_close = !wr_win && wr_win_q;

    // Remember the previous window state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_win_q <= 1'b0;
            wr_win_q <= 1'b0;
        end else begin
            rd_win_q <= rd_win;
            wr_win_q <= wr_win;
        end
    end

    // Capture the lane and status selects when a transfer opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_bsel <= 1'b0;
            sel_ssel <= 1'b0;
        end else if (rd_open || wr_open) begin
            sel_bsel <= s_bsel;
            sel_ssel <= s_ssel;
        end
    end

    // Drive the bus straight from the raw pins for a fast release.
    assign bus_oe = !raw_cs_n && !raw_rd_n;

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win_q && rd_win && !wr_open) |=> $stable({sel_bsel, sel_ssel})); // R4
endmodule

// File: rtl/hp_regs.sv
// Register bank: the input word written by the host, the outgoing word
// loaded by the core, both full flags and the read byte multiplexer.
// Assumes: close pulses last one cycle; sel_* are held for the transfer.
module hp_regs #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_close,
    input  logic                  wr_close,
    input  logic                  sel_bsel,
    input  logic                  sel_ssel,
    input  logic [BYTE_W-1:0]     wr_byte,
    input  logic                  raw_bsel,
    input  logic                  raw_ssel,
    input  logic [2*BYTE_W-1:0]   core_out_data,
    input  logic                  core_out_load,
    input  logic                  core_in_take,
    output logic [2*BYTE_W-1:0]   in_data,
    output logic                  in_full,
    output logic                  out_full,
    output logic [BYTE_W-1:0]     rd_byte
);
    import hp_pkg::*;
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] out_word, stat_word, sel_word;
    logic              data_wr, hi_wr, hi_rd;

    assign data_wr = wr_close && !sel_ssel;
    assign hi_wr   = data_wr && sel_bsel;
    assign hi_rd   = rd_close && !sel_ssel && sel_bsel;

    // Store one host byte into the lane picked at the opening.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_data <= '0;
        else if (data_wr && sel_bsel)
            in_data[WORD_W-1:BYTE_W] <= wr_byte;
        else if (data_wr)
            in_data[BYTE_W-1:0] <= wr_byte;
    end

    // Input-full flag: set by a high-lane write, which wins over a take.
    always_ff @(posedge clk) begin
        if (!rst_n)            in_full <= 1'b0;
        else if (hi_wr)        in_full <= 1'b1;
        else if (core_in_take) in_full <= 1'b0;
    end

    // Outgoing word and flag: a core load wins over a high-lane read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_full <= 1'b0;
        end else if (core_out_load) begin
            out_word <= core_out_data;
            out_full <= 1'b1;
        end else if (hi_rd) begin
            out_full <= 1'b0;
        end
    end

    // Build the status word and select the byte presented on the bus.
    always_comb begin
        stat_word                    = '0;
        stat_word[STAT_IN_FULL_BIT]  = in_full;
        stat_word[STAT_OUT_FULL_BIT] = out_full;
        sel_word = raw_ssel ? stat_word : out_word;
        rd_byte  = raw_bsel ? sel_word[WORD_W-1:BYTE_W] : sel_word[BYTE_W-1:0];
    end

    AST_IN_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_close && !sel_ssel && sel_bsel) |=> in_full); // R7
    AST_OUT_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_load |=> out_full); // R8
    AST_OUT_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_close && !sel_ssel && sel_bsel && !core_out_load) |=> !out_full); // R8
    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_close && sel_ssel) |=> $stable(in_data)); // R9
endmodule

// File: rtl/byte_host_port.sv
// Top of the byte-wide host register port: synchronizes the host pins,
// frames transfers, holds the registers and drives the tri-state bus.
// Assumes: the host holds selects for a transfer and write data for at
// least SYNC_STAGES clocks after its closing edge.
module byte_host_port #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_cs_n,
    input  logic                  host_rd_n,
    input  logic                  host_wr_n,
    input  logic                  host_bsel,
    input  logic                  host_ssel,
    inout  wire  [BYTE_W-1:0]     host_data,
    input  logic [2*BYTE_W-1:0]   core_out_data,
    input  logic                  core_out_load,
    output logic [2*BYTE_W-1:0]   core_in_data,
    output logic                  core_in_full,
    input  logic                  core_in_take,
    output logic                  core_out_full
);
    localparam int               SYNC_W    = 5 + BYTE_W;
    localparam logic [SYNC_W-1:0] SYNC_IDLE = {3'b111, {(SYNC_W-3){1'b0}}};

    logic [SYNC_W-1:0] pins_raw, pins_s;
    logic              rd_close, wr_close, sel_bsel, sel_ssel, bus_oe;
    logic [BYTE_W-1:0] rd_byte;

    assign pins_raw = {host_cs_n, host_rd_n, host_wr_n, host_bsel, host_ssel, host_data};

    hp_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .IDLE(SYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    hp_framer u_framer (
        .clk(clk), .rst_n(rst_n),
        .s_cs_n(pins_s[SYNC_W-1]), .s_rd_n(pins_s[SYNC_W-2]), .s_wr_n(pins_s[SYNC_W-3]),
        .s_bsel(pins_s[SYNC_W-4]), .s_ssel(pins_s[SYNC_W-5]),
        .raw_cs_n(host_cs_n), .raw_rd_n(host_rd_n),
        .rd_close(rd_close), .wr_close(wr_close),
        .sel_bsel(sel_bsel), .sel_ssel(sel_ssel), .bus_oe(bus_oe)
    );

    hp_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .rd_close(rd_close), .wr_close(wr_close),
        .sel_bsel(sel_bsel), .sel_ssel(sel_ssel),
        .wr_byte(pins_s[BYTE_W-1:0]),
        .raw_bsel(host_bsel), .raw_ssel(host_ssel),
        .core_out_data(core_out_data), .core_out_load(core_out_load),
        .core_in_take(core_in_take),
        .in_data(core_in_data), .in_full(core_in_full),
        .out_full(core_out_full), .rd_byte(rd_byte)
    );

    // Tri-state driver of the host data bus.
    assign host_data = bus_oe ? rd_byte : {BYTE_W{1'bz}};

    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_n || host_rd_n) |-> !bus_oe); // R5
    AST_BUS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs_n && !host_rd_n) |-> bus_oe); // R5
endmodule

// File: tb/tb_byte_host_port.sv
module tb_byte_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int BW         = 8;
    localparam int STAGES     = 2;

    typedef struct packed {
        logic cs, rd, wr, bs, ss;
        logic [BW-1:0] d;
    } pins_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, bsel = 1'b0, ssel = 1'b0;
    logic [BW-1:0] tb_dq = '0;
    logic tb_dq_en = 1'b0;
    wire  [BW-1:0] host_data;
    logic [2*BW-1:0] out_data = '0, in_data;
    logic out_load = 1'b0, in_take = 1'b0, in_full, out_full;
    int n_cmp = 0, n_bad = 0;

    assign host_data = tb_dq_en ? tb_dq : {BW{1'bz}};
    always #(CLK_PERIOD/2) clk = ~clk;

    byte_host_port #(.BYTE_W(BW), .SYNC_STAGES(STAGES)) dut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
        .host_bsel(bsel), .host_ssel(ssel), .host_data(host_data),
        .core_out_data(out_data), .core_out_load(out_load), .core_in_data(in_data),
        .core_in_full(in_full), .core_in_take(in_take), .core_out_full(out_full)
    );

    // ---------------- behavioural reference model ----------------
    pins_t pipe[$];
    logic m_rd = 0, m_wr = 0, m_bs = 0, m_ss = 0, m_ibf = 0, m_obf = 0;
    logic [2*BW-1:0] m_in = '0, m_out = '0;

    always @(posedge clk) begin
        pins_t cur, s;
        logic rd_now, wr_now;
        cur = '{cs: cs_n, rd: rd_n, wr: wr_n, bs: bsel, ss: ssel, d: host_data};
        if (!rst_n) begin
            m_rd = 0; m_wr = 0; m_bs = 0; m_ss = 0; m_ibf = 0; m_obf = 0;
            m_in = '0; m_out = '0;
            pipe.delete();
            for (int i = 0; i < STAGES; i++) pipe.push_back('{cs: 1, rd: 1, wr: 1, bs: 0, ss: 0, d: '0});
        end else begin
            s = pipe.pop_front();
            pipe.push_back(cur);
            rd_now = !s.cs && !s.rd;
            wr_now = !s.cs && !s.wr;
            if (in_take) m_ibf = 0;
            if (!wr_now && m_wr && !m_ss) begin
                if (m_bs) begin m_in[2*BW-1:BW] = s.d; m_ibf = 1; end
                else m_in[BW-1:0] = s.d;
            end
            if (!rd_now && m_rd && !m_ss && m_bs) m_obf = 0;
            if (out_load) begin m_out = out_data; m_obf = 1; end
            if ((rd_now && !m_rd) || (wr_now && !m_wr)) begin m_bs = s.bs; m_ss = s.ss; end
            m_rd = rd_now; m_wr = wr_now;
        end
    end

    function automatic logic [BW-1:0] exp_bus();
        logic [2*BW-1:0] w;
        w = ssel ? {{(2*BW-2){1'b0}}, m_obf, m_ibf} : m_out;
        return bsel ? w[2*BW-1:BW] : w[BW-1:0];
    endfunction

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (in_data !== m_in) begin n_bad++; $display("FAIL R3 input word got %h exp %h", in_data, m_in); end
            if (in_full !== m_ibf) begin n_bad++; $display("FAIL R7 in_full got %0d exp %0d", in_full, m_ibf); end
            if (out_full !== m_obf) begin n_bad++; $display("FAIL R8 out_full got %0d exp %0d", out_full, m_obf); end
            if (!cs_n && !rd_n && host_data !== exp_bus()) begin
                n_bad++; $display("FAIL R5 bus got %h exp %h", host_data, exp_bus());
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic check(input logic [2*BW-1:0] got, input logic [2*BW-1:0] exp, input string tag);
        n_cmp++;
        if (got !== exp) begin n_bad++; $display("FAIL %s got %h exp %h", tag, got, exp); end
    endtask

    task automatic host_write(input logic b, input logic s, input logic [BW-1:0] v, input logic cs_lead);
        bsel = b; ssel = s; tb_dq = v; tb_dq_en = 1;
        if (cs_lead) begin cs_n = 0; step(2); wr_n = 0; step(4); wr_n = 1; step(2); cs_n = 1; end
        else begin wr_n = 0; step(2); cs_n = 0; step(4); cs_n = 1; step(2); wr_n = 1; end
        step(3); tb_dq_en = 0; step(1);
    endtask

    task automatic host_read(input logic b, input logic s, input logic cs_lead, output logic [BW-1:0] got);
        bsel = b; ssel = s;
        if (cs_lead) begin cs_n = 0; step(2); rd_n = 0; end
        else begin rd_n = 0; step(2); cs_n = 0; end
        step(2); got = host_data; step(2);
        if (cs_lead) begin rd_n = 1; step(2); cs_n = 1; end
        else begin cs_n = 1; step(2); rd_n = 1; end
        step(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog got running exp finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [BW-1:0] got;
        step(3); rst_n = 1; step(1);
        check(in_full, 0, "R1 in_full after reset");
        check(out_full, 0, "R1 out_full after reset");
        check(in_data, 0, "R1 in_data after reset");

        host_write(0, 0, 8'h3C, 1);                     // R4 low lane, select leads
        check(in_data[BW-1:0], 8'h3C, "R4 low lane");
        check(in_full, 0, "R7 no set on low lane");
        host_write(1, 0, 8'hA5, 0);                     // R4 high lane, select lags
        check(in_data, 16'hA53C, "R4 high lane");
        check(in_full, 1, "R7 set on high lane");
        in_take = 1; step(1); in_take = 0; step(1);
        check(in_full, 0, "R7 take clears");

        host_write(1, 1, 8'hFF, 1);                     // R9 status write ignored
        check(in_data, 16'hA53C, "R9 word unchanged");
        check(in_full, 0, "R9 flag unchanged");

        out_data = 16'hBEEF; out_load = 1; step(1); out_load = 0; step(1);
        check(out_full, 1, "R8 load sets");
        host_read(0, 1, 1, got);
        check(got, 8'h02, "R6 status low byte");
        host_read(1, 1, 0, got);
        check(got, 8'h00, "R6 status high byte");
        host_read(0, 0, 0, got);
        check(got, 8'hEF, "R5 low data byte");
        check(out_full, 1, "R8 low read keeps flag");
        host_read(1, 0, 1, got);
        check(got, 8'hBE, "R5 high data byte");
        check(out_full, 0, "R8 high read clears");

        // R3: strobe rises first, bus changes before the select rises.
        bsel = 0; ssel = 0; tb_dq = 8'h11; tb_dq_en = 1;
        cs_n = 0; step(2); wr_n = 0; step(4); wr_n = 1; step(3);
        tb_dq = 8'h22; step(2); cs_n = 1; step(4); tb_dq_en = 0;
        check(in_data[BW-1:0], 8'h11, "R3 close on strobe rise");
        // R3: select rises first, bus changes before the strobe rises.
        tb_dq = 8'h33; tb_dq_en = 1;
        wr_n = 0; step(2); cs_n = 0; step(4); cs_n = 1; step(3);
        tb_dq = 8'h44; step(2); wr_n = 1; step(4); tb_dq_en = 0;
        check(in_data[BW-1:0], 8'h33, "R3 close on select rise");

        // R2: lane changes between the two falling edges; the later one opens.
        out_load = 1; step(1); out_load = 0;
        bsel = 0; cs_n = 0; step(3); bsel = 1; step(3); rd_n = 0; step(4);
        rd_n = 1; step(1); cs_n = 1; step(4);
        check(out_full, 0, "R2 opening on strobe fall");
        out_load = 1; step(1); out_load = 0;
        bsel = 0; rd_n = 0; step(3); bsel = 1; step(3); cs_n = 0; step(4);
        cs_n = 1; step(1); rd_n = 1; step(4);
        check(out_full, 0, "R2 opening on select fall");

        // R10: closing edge applied after edge k-1 acts at edge k+2.
        out_load = 1; step(1); out_load = 0;
        bsel = 1; ssel = 0; cs_n = 0; step(1); rd_n = 0; step(5);
        rd_n = 1; step(2);
        check(out_full, 1, "R10 not yet cleared");
        step(1);
        check(out_full, 0, "R10 cleared at k+2");
        cs_n = 1; step(3);

        // R7: take coincides with the high-lane closing; set wins.
        bsel = 1; tb_dq = 8'h5A; tb_dq_en = 1; cs_n = 0; step(1); wr_n = 0; step(4);
        wr_n = 1; step(2); in_take = 1; step(1); in_take = 0;
        check(in_full, 1, "R7 set wins over take");
        step(3); cs_n = 1; tb_dq_en = 0; step(4);
        check(in_data[2*BW-1:BW], 8'h5A, "R4 high lane second write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule